// File: doc/BRIEF.md
# I2C Controller Transaction Sequencer

This block is the byte-level sequencer of an I2C controller. Software writes the target address into two byte registers, sets a read length and an addressing mode, and then writes the first address byte to launch a transaction. The sequencer sends a start, the address byte or bytes, and then either moves data bytes out of a transmit FIFO or collects the requested number of bytes into a receive FIFO. When the transfer finishes it closes the bus with a stop. Bit timing and line handling belong to a separate bit engine, which takes one command at a time (start, stop, write byte, read byte) and returns one response for each.

If the first address byte is written again while a transaction runs, and the sequencer has already begun sending the device address, the sequencer does not stop. It queues a repeated start instead. In a write phase the repeated start is taken when the transmit FIFO runs dry. In a read phase it is taken when the read count has been reached. The new address then applies. For 10-bit targets, a read launched from idle first selects the target with both address bytes in write direction, then re-addresses with only the first byte in read direction. A queued read re-address also sends only the first byte.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset, busy_o, err_o, cmd_valid_o and tx_req_o are 0. A write to register select 0 while idle starts a transaction: busy_o rises and the first command is a start, followed by a write of the first address byte (bit 0 is the direction, 1 = read).
- R2: In 7-bit mode (mode register select 3, bit 0 = 0), the first address byte is sent as written. In a write phase, each transmit FIFO byte is sent in order, with one tx_pop_o per accepted write command.
- R3: When a write phase finds the transmit FIFO empty and no repeated start is queued, the sequencer issues a stop and busy_o falls after the stop response.
- R4: A read phase issues exactly the read length (register select 2) of read commands. cmd_nack_o is 1 only on the last one. Each returned byte is pushed to the receive FIFO with a one-cycle rx_req_o. No read command is presented while rx_full_i is 1.
- R5: In 10-bit mode (mode bit 0 = 1), a write transaction sends start, the first address byte, and then the second address byte (register select 1).
- R6: A 10-bit read started from idle sends start, the first byte with bit 0 forced to 0, the second byte, a repeated start, and the first byte with bit 0 = 1, and then reads.
- R7: A write to select 0 while busy, after the first address byte of the current phase has been accepted, queues a repeated start. In a write phase it is issued, without a stop, when the transmit FIFO is empty, and the new byte is then sent.
- R8: A queued repeated start in a read phase is issued, without a stop, once the read length is reached.
- R9: A write to select 0 while busy, before the first address byte of the phase has been accepted, is ignored: the transaction ends with a stop and no repeated start.
- R10: In 10-bit mode, a queued repeated start with bit 0 = 1 sends only the first address byte before reading.
- R11: A NACK on either address byte aborts the transaction with a stop and sets err_o. err_o stays set until the next transaction starts from idle.
- R12: tx_req_o is 1 while a data byte is in flight in a write phase and the transmit FIFO is empty. A byte pushed in that window is sent before the phase ends.
- R13: A command on cmd_valid_o stays present and unchanged until cmd_ready_i accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 first address byte, 1 second address byte, 2 read length, 3 mode |
| reg_wdata_i | input | 8 | Register write data |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_data_i | input | 8 | Transmit FIFO head byte |
| tx_pop_o | output | 1 | Transmit FIFO pop |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_push_o | output | 1 | Receive FIFO push |
| rx_data_o | output | 8 | Received byte |
| cmd_valid_o | output | 1 | Bit-engine command valid |
| cmd_ready_i | input | 1 | Bit-engine command accept |
| cmd_op_o | output | 2 | Command: 0 start, 1 stop, 2 write byte, 3 read byte |
| cmd_byte_o | output | 8 | Byte to write |
| cmd_nack_o | output | 1 | Answer a read byte with NACK |
| rsp_valid_i | input | 1 | Bit-engine response for the accepted command |
| rsp_nack_i | input | 1 | Target answered a written byte with NACK |
| rsp_byte_i | input | 8 | Byte returned by a read |
| busy_o | output | 1 | Transaction in progress |
| err_o | output | 1 | Address NACK seen in the last transaction |
| tx_req_o | output | 1 | Transmit data request |
| rx_req_o | output | 1 | Received byte available (pulse) |

## Verification
The hardest situations to reach are the timing windows around an address rewrite. The bench watches the command stream from its own bit-engine model. It rewrites the first address byte only after the first address command has been logged, and in another test it rewrites it one cycle after launch, while the start command is still in flight. The engine model stretches its accept delay in a rotating pattern, so commands are held unaccepted for zero to two cycles. A refill of the transmit FIFO is pushed only while tx_req_o is high, to show that the boundary check comes after the in-flight byte completes. The 10-bit re-address paths are covered by comparing the whole logged command sequence, including the forced direction bit.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADR1,
    ST_ADR2,
    ST_XFER,
    ST_STOP
  } st_e;
endpackage

// File: rtl/i2c_seq_regs.sv
module i2c_seq_regs
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              armed_i,
  input  logic              take_rs_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic              ten_o,
  output logic [CNT_W-1:0]  len_o,
  output logic              rs_pend_o,
  output logic              start_o
);
  logic [BYTE_W-1:0] hi_q, next_q, lo_q;
  logic [CNT_W-1:0]  len_q;
  logic              ten_q, rs_q;
  logic              wr_hi, rs_accept;

  assign wr_hi     = we_i && (sel_i == 2'd0);
  assign start_o   = wr_hi && !busy_i;
  assign rs_accept = wr_hi && busy_i && armed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      next_q <= '0;
      lo_q   <= '0;
      len_q  <= '0;
      ten_q  <= 1'b0;
      rs_q   <= 1'b0;
    end else begin
      if (start_o) begin
        hi_q <= wdata_i;
        rs_q <= 1'b0;
      end else if (take_rs_i) begin
        hi_q <= next_q;
        rs_q <= 1'b0;
      end else if (rs_accept) begin
        next_q <= wdata_i;
        rs_q   <= 1'b1;
      end
      if (we_i && sel_i == 2'd1) lo_q  <= wdata_i;
      if (we_i && sel_i == 2'd2) len_q <= CNT_W'(wdata_i);
      if (we_i && sel_i == 2'd3) ten_q <= wdata_i[0];
    end
  end

  assign hi_o      = hi_q;
  assign lo_o      = lo_q;
  assign ten_o     = ten_q;
  assign len_o     = len_q;
  assign rs_pend_o = rs_q;

  // R9: a queued restart only ever follows a write seen while armed
  a_r9_pend_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rs_q) |-> $past(armed_i && busy_i));
endmodule

// File: rtl/i2c_seq_rxctr.sv
module i2c_seq_rxctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == len_i);
  assign last_o = ({1'b0, cnt_q} + 1'b1) == {1'b0, len_i};

  // R4: never count past the requested length
  a_r4_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !done_o);
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic              ten_i,
  input  logic              rs_pend_i,
  input  logic              rx_done_i,
  input  logic              rx_last_i,
  input  logic              tx_empty_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              rx_full_i,
  input  logic              cmd_ready_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_nack_i,
  input  logic [BYTE_W-1:0] rsp_byte_i,
  output logic              busy_o,
  output logic              armed_o,
  output logic              take_rs_o,
  output logic              rx_clr_o,
  output logic              rx_inc_o,
  output logic              cmd_valid_o,
  output op_e               cmd_op_o,
  output logic [BYTE_W-1:0] cmd_byte_o,
  output logic              cmd_nack_o,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              tx_req_o,
  output logic              rx_req_o,
  output logic              err_o
);
  st_e  st_q;
  logic wait_q, armed_q, resend_q, pre10_q, err_q;
  logic want, cmd_hs, rsp_ev, rw, xfer_end;

  assign rw = hi_i[0];

  always_comb begin
    want       = 1'b0;
    cmd_op_o   = OP_START;
    cmd_byte_o = '0;
    cmd_nack_o = 1'b0;
    case (st_q)
      ST_START: want = 1'b1;
      ST_ADR1: begin
        want       = 1'b1;
        cmd_op_o   = OP_WRITE;
        cmd_byte_o = {hi_i[7:1], hi_i[0] & ~pre10_q};  // 10-bit read selects in write direction first
      end
      ST_ADR2: begin
        want       = 1'b1;
        cmd_op_o   = OP_WRITE;
        cmd_byte_o = lo_i;
      end
      ST_XFER: begin
        if (!rw) begin
          cmd_op_o   = OP_WRITE;
          cmd_byte_o = tx_data_i;
          want       = !tx_empty_i;
        end else begin
          cmd_op_o   = OP_READ;
          cmd_nack_o = rx_last_i;
          want       = !rx_done_i && !rx_full_i;
        end
      end
      ST_STOP: begin
        want     = 1'b1;
        cmd_op_o = OP_STOP;
      end
      default: ;
    endcase
  end

  assign cmd_valid_o = want && !wait_q;
  assign cmd_hs      = cmd_valid_o && cmd_ready_i;
  assign rsp_ev      = wait_q && rsp_valid_i;
  assign xfer_end    = (st_q == ST_XFER) && !wait_q && (rw ? rx_done_i : tx_empty_i);
  assign take_rs_o   = xfer_end && rs_pend_i;
  assign rx_clr_o    = cmd_hs && (st_q == ST_START);
  assign rx_inc_o    = rsp_ev && (st_q == ST_XFER) && rw;
  assign rx_push_o   = rx_inc_o;
  assign rx_req_o    = rx_inc_o;
  assign rx_data_o   = rsp_byte_i;
  assign tx_pop_o    = cmd_hs && (st_q == ST_XFER) && !rw;
  assign tx_req_o    = (st_q == ST_XFER) && !rw && wait_q && tx_empty_i;
  assign busy_o      = (st_q != ST_IDLE);
  assign armed_o     = armed_q;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      wait_q   <= 1'b0;
      armed_q  <= 1'b0;
      resend_q <= 1'b0;
      pre10_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (rsp_ev)      wait_q <= 1'b0;
      else if (cmd_hs) wait_q <= 1'b1;
      if (cmd_hs && st_q == ST_ADR1) armed_q <= 1'b1;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q     <= ST_START;
          err_q    <= 1'b0;
          resend_q <= 1'b0;
          pre10_q  <= 1'b0;
        end
        ST_START: if (rsp_ev) begin
          st_q <= ST_ADR1;
          if (!resend_q) pre10_q <= ten_i && hi_i[0];
        end
        ST_ADR1: if (rsp_ev) begin
          if (rsp_nack_i) begin
            err_q   <= 1'b1;
            armed_q <= 1'b0;
            st_q    <= ST_STOP;
          end else if (ten_i && !(resend_q && hi_i[0])) begin
            st_q <= ST_ADR2;
          end else begin
            st_q <= ST_XFER;
          end
        end
        ST_ADR2: if (rsp_ev) begin
          if (rsp_nack_i) begin
            err_q   <= 1'b1;
            armed_q <= 1'b0;
            st_q    <= ST_STOP;
          end else if (pre10_q) begin
            pre10_q  <= 1'b0;
            resend_q <= 1'b1;
            st_q     <= ST_START;
          end else begin
            st_q <= ST_XFER;
          end
        end
        ST_XFER: if (xfer_end) begin
          armed_q <= 1'b0;
          if (rs_pend_i) begin
            resend_q <= 1'b1;
            st_q     <= ST_START;
          end else begin
            st_q <= ST_STOP;
          end
        end
        ST_STOP: if (rsp_ev) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R13: command holds until accepted
  a_r13_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_byte_o));
  // R11: address NACK goes straight to stop with error
  a_r11_addr_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ev && rsp_nack_i && (st_q == ST_ADR1 || st_q == ST_ADR2) |=> (st_q == ST_STOP) && err_o);
  // R2: no pop from an empty transmit FIFO
  a_r2_pop_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i);
  // R4: no read presented while the receive FIFO is full
  a_r4_full_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && (cmd_op_o == OP_READ) |-> !rx_full_i);
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       tx_empty_i,
  input  logic [7:0] tx_data_i,
  output logic       tx_pop_o,
  input  logic       rx_full_i,
  output logic       rx_push_o,
  output logic [7:0] rx_data_o,
  output logic       cmd_valid_o,
  input  logic       cmd_ready_i,
  output logic [1:0] cmd_op_o,
  output logic [7:0] cmd_byte_o,
  output logic       cmd_nack_o,
  input  logic       rsp_valid_i,
  input  logic       rsp_nack_i,
  input  logic [7:0] rsp_byte_i,
  output logic       busy_o,
  output logic       err_o,
  output logic       tx_req_o,
  output logic       rx_req_o
);
  logic [BYTE_W-1:0] hi, lo;
  logic [CNT_W-1:0]  len;
  logic ten, rs_pend, start, armed, take_rs, rx_clr, rx_inc, rx_done, rx_last;
  op_e  op;

  i2c_seq_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .busy_i(busy_o), .armed_i(armed), .take_rs_i(take_rs),
    .hi_o(hi), .lo_o(lo), .ten_o(ten), .len_o(len), .rs_pend_o(rs_pend), .start_o(start)
  );

  i2c_seq_rxctr #(.CNT_W(CNT_W)) u_rxctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rx_clr), .inc_i(rx_inc), .len_i(len),
    .done_o(rx_done), .last_o(rx_last)
  );

  i2c_seq_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .hi_i(hi), .lo_i(lo), .ten_i(ten),
    .rs_pend_i(rs_pend), .rx_done_i(rx_done), .rx_last_i(rx_last),
    .tx_empty_i(tx_empty_i), .tx_data_i(tx_data_i), .rx_full_i(rx_full_i),
    .cmd_ready_i(cmd_ready_i), .rsp_valid_i(rsp_valid_i), .rsp_nack_i(rsp_nack_i),
    .rsp_byte_i(rsp_byte_i), .busy_o(busy_o), .armed_o(armed), .take_rs_o(take_rs),
    .rx_clr_o(rx_clr), .rx_inc_o(rx_inc), .cmd_valid_o(cmd_valid_o), .cmd_op_o(op),
    .cmd_byte_o(cmd_byte_o), .cmd_nack_o(cmd_nack_o), .tx_pop_o(tx_pop_o),
    .rx_push_o(rx_push_o), .rx_data_o(rx_data_o), .tx_req_o(tx_req_o),
    .rx_req_o(rx_req_o), .err_o(err_o)
  );

  assign cmd_op_o = op;
endmodule

// File: tb/i2c_txn_seq_test.sv
module i2c_txn_seq_test;
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WR = 2'd2, C_RD = 2'd3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic       tx_empty, tx_pop, rx_full = 1'b0, rx_push, cmd_valid, cmd_nack;
  logic [7:0] tx_data, rx_data, cmd_byte;
  logic [1:0] cmd_op;
  logic       cmd_ready = 1'b0, rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic [7:0] rsp_byte = '0;
  logic       busy, err, tx_req, rx_req;

  int total = 0, bad = 0;
  logic [1:0] lop [64];
  logic [7:0] lbyte [64];
  logic       lnack [64];
  int ncmd = 0;
  logic [7:0] txq [64];
  int txw = 0, txr = 0;
  logic [7:0] rxq [64];
  logic [7:0] rd_ret [64];
  int nrx = 0, nrd = 0, nrq = 0, txreq_cyc = 0, refill = 0;
  logic       nack_en = 1'b0;
  logic [7:0] nack_byte = '0;

  always #10 clk = ~clk;

  i2c_txn_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .tx_empty_i(tx_empty), .tx_data_i(tx_data), .tx_pop_o(tx_pop), .rx_full_i(rx_full),
    .rx_push_o(rx_push), .rx_data_o(rx_data), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_op_o(cmd_op), .cmd_byte_o(cmd_byte), .cmd_nack_o(cmd_nack), .rsp_valid_i(rsp_valid),
    .rsp_nack_i(rsp_nack), .rsp_byte_i(rsp_byte), .busy_o(busy), .err_o(err),
    .tx_req_o(tx_req), .rx_req_o(rx_req)
  );

  assign tx_empty = (txr == txw);
  assign tx_data  = txq[txr % 64];

  always @(posedge clk) begin
    if (tx_pop) txr <= txr + 1;
    if (rx_push) begin
      rxq[nrx % 64] <= rx_data;
      nrx <= nrx + 1;
    end
    if (rx_req) nrq <= nrq + 1;
  end

  always @(negedge clk) begin
    if (tx_req) begin
      txreq_cyc = txreq_cyc + 1;
      if (refill > 0) begin
        txq[txw % 64] = 8'h22;
        txw = txw + 1;
        refill = refill - 1;
      end
    end
  end

  // bit-engine model with rotating accept delay
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        repeat (ncmd % 3) @(negedge clk);
        cmd_ready = 1'b1;
        lop[ncmd % 64]   = cmd_op;
        lbyte[ncmd % 64] = cmd_byte;
        lnack[ncmd % 64] = cmd_nack;
        rsp_nack = (cmd_op == C_WR) && nack_en && (cmd_byte == nack_byte);
        rsp_byte = 8'hC0 + 8'(nrd);
        if (cmd_op == C_RD) begin
          rd_ret[nrd % 64] = rsp_byte;
          nrd = nrd + 1;
        end
        ncmd = ncmd + 1;
        @(negedge clk);
        cmd_ready = 1'b0;
        repeat (2) @(negedge clk);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_cmd(string rq, int i, logic [1:0] op, logic [7:0] b, logic nk);
    logic [31:0] act, exp;
    act = {22'd0, lop[i], lbyte[i]};
    exp = {22'd0, op, b};
    if (op == C_START || op == C_STOP) begin act[7:0] = '0; exp[7:0] = '0; end
    if (op == C_RD) begin act[7:0] = {7'd0, lnack[i]}; exp[7:0] = {7'd0, nk}; end
    chk($sformatf("%s cmd%0d", rq, i), act, exp);
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push_tx(logic [7:0] d);
    txq[txw % 64] = d;
    txw = txw + 1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 err", {31'd0, err}, 0);
    chk("R1 valid", {31'd0, cmd_valid}, 0);
    chk("R1 txreq", {31'd0, tx_req}, 0);
  endtask

  task automatic t_write7();
    ncmd = 0; txreq_cyc = 0;
    wr(2'd3, 8'h00);
    push_tx(8'h11);
    refill = 1;
    wr(2'd0, 8'hA0);
    chk("R1 busy after start", {31'd0, busy}, 1);
    wait_idle();
    chk("R2 count", ncmd, 5);
    chk_cmd("R1", 0, C_START, 0, 0);
    chk_cmd("R2", 1, C_WR, 8'hA0, 0);
    chk_cmd("R2", 2, C_WR, 8'h11, 0);
    chk_cmd("R12 refill", 3, C_WR, 8'h22, 0);
    chk_cmd("R3", 4, C_STOP, 0, 0);
    chk("R12 txreq seen", {31'd0, txreq_cyc > 0}, 1);
    chk("R3 busy low", {31'd0, busy}, 0);
    chk("R12 txreq idle", {31'd0, tx_req}, 0);
  endtask

  task automatic t_read7();
    int rx0, rq0, rd0;
    ncmd = 0; rx0 = nrx; rq0 = nrq; rd0 = nrd;
    rx_full = 1'b1;
    wr(2'd2, 8'd3);
    wr(2'd0, 8'hA1);
    repeat (30) @(negedge clk);
    chk("R4 stall on full", ncmd, 2);
    rx_full = 1'b0;
    wait_idle();
    chk("R4 count", ncmd, 6);
    chk_cmd("R4", 2, C_RD, 0, 0);
    chk_cmd("R4", 3, C_RD, 0, 0);
    chk_cmd("R4 last nack", 4, C_RD, 0, 1);
    chk_cmd("R4", 5, C_STOP, 0, 0);
    chk("R4 pushes", nrx - rx0, 3);
    chk("R4 rxreq", nrq - rq0, 3);
    for (int k = 0; k < 3; k++)
      chk("R4 data", {24'd0, rxq[(rx0 + k) % 64]}, {24'd0, rd_ret[(rd0 + k) % 64]});
  endtask

  task automatic t_rs_write();
    ncmd = 0;
    wr(2'd2, 8'd2);
    push_tx(8'h31); push_tx(8'h32);
    wr(2'd0, 8'hA0);
    wait (ncmd >= 2);
    wr(2'd0, 8'hA1);
    wait_idle();
    chk("R7 count", ncmd, 9);
    chk_cmd("R7", 2, C_WR, 8'h31, 0);
    chk_cmd("R7", 3, C_WR, 8'h32, 0);
    chk_cmd("R7 restart", 4, C_START, 0, 0);
    chk_cmd("R7 new addr", 5, C_WR, 8'hA1, 0);
    chk_cmd("R7", 6, C_RD, 0, 0);
    chk_cmd("R7", 7, C_RD, 0, 1);
    chk_cmd("R7", 8, C_STOP, 0, 0);
  endtask

  task automatic t_rs_read();
    ncmd = 0;
    wr(2'd2, 8'd3);
    push_tx(8'h44);
    wr(2'd0, 8'hA1);
    wait (ncmd >= 2);
    wr(2'd0, 8'hA0);
    wait_idle();
    chk("R8 count", ncmd, 9);
    chk_cmd("R8", 4, C_RD, 0, 1);
    chk_cmd("R8 restart", 5, C_START, 0, 0);
    chk_cmd("R8 new addr", 6, C_WR, 8'hA0, 0);
    chk_cmd("R8", 7, C_WR, 8'h44, 0);
    chk_cmd("R8", 8, C_STOP, 0, 0);
  endtask

  task automatic t_early();
    ncmd = 0;
    push_tx(8'h55);
    wr(2'd0, 8'hA0);
    wr(2'd0, 8'hA1);
    wait_idle();
    chk("R9 count", ncmd, 4);
    chk_cmd("R9", 1, C_WR, 8'hA0, 0);
    chk_cmd("R9", 2, C_WR, 8'h55, 0);
    chk_cmd("R9 stop", 3, C_STOP, 0, 0);
  endtask

  task automatic t_ten_write();
    ncmd = 0;
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h34);
    push_tx(8'h66);
    wr(2'd0, 8'hF6);
    wait_idle();
    chk("R5 count", ncmd, 5);
    chk_cmd("R5", 1, C_WR, 8'hF6, 0);
    chk_cmd("R5", 2, C_WR, 8'h34, 0);
    chk_cmd("R5", 3, C_WR, 8'h66, 0);
    chk_cmd("R5", 4, C_STOP, 0, 0);
  endtask

  task automatic t_ten_read();
    ncmd = 0;
    wr(2'd2, 8'd2);
    wr(2'd0, 8'hF3);
    wait_idle();
    chk("R6 count", ncmd, 8);
    chk_cmd("R6 forced write", 1, C_WR, 8'hF2, 0);
    chk_cmd("R6", 2, C_WR, 8'h34, 0);
    chk_cmd("R6 restart", 3, C_START, 0, 0);
    chk_cmd("R6 read dir", 4, C_WR, 8'hF3, 0);
    chk_cmd("R6", 5, C_RD, 0, 0);
    chk_cmd("R6", 6, C_RD, 0, 1);
    chk_cmd("R6", 7, C_STOP, 0, 0);
  endtask

  task automatic t_ten_rs();
    ncmd = 0;
    wr(2'd2, 8'd1);
    push_tx(8'h77);
    wr(2'd0, 8'hF2);
    wait (ncmd >= 2);
    wr(2'd0, 8'hF3);
    wait_idle();
    chk("R10 count", ncmd, 8);
    chk_cmd("R10", 3, C_WR, 8'h77, 0);
    chk_cmd("R10", 4, C_START, 0, 0);
    chk_cmd("R10 short", 5, C_WR, 8'hF3, 0);
    chk_cmd("R10", 6, C_RD, 0, 1);
    chk_cmd("R10", 7, C_STOP, 0, 0);
  endtask

  task automatic t_nack();
    ncmd = 0;
    nack_en = 1'b1;
    nack_byte = 8'h34;
    wr(2'd0, 8'hF2);
    wait_idle();
    chk("R11 second byte count", ncmd, 4);
    chk_cmd("R11", 3, C_STOP, 0, 0);
    chk("R11 err", {31'd0, err}, 1);
    ncmd = 0;
    wr(2'd3, 8'h00);
    nack_byte = 8'h90;
    wr(2'd0, 8'h90);
    wait_idle();
    chk("R11 first byte count", ncmd, 3);
    chk_cmd("R11", 2, C_STOP, 0, 0);
    chk("R11 err held", {31'd0, err}, 1);
    chk("R11 busy", {31'd0, busy}, 0);
    nack_en = 1'b0;
    ncmd = 0;
    wr(2'd0, 8'hA0);
    wait_idle();
    chk("R11 err cleared", {31'd0, err}, 0);
    chk("R3 empty write", ncmd, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write7();
    t_read7();
    t_rs_write();
    t_rs_read();
    t_early();
    t_ten_write();
    t_ten_read();
    t_ten_rs();
    t_nack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule